// File: doc/BRIEF.md
# Serial Setpoint Receiver

This block takes a 12-bit current setpoint from a slow four-wire serial link into the system clock domain. The four lines are an active-low shift enable (strobe), a commit line (latch), a serial clock and serial data. All four are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and edges are found on the synchronized copies.

While the strobe is low, every low-to-high edge of the serial clock shifts one bit into an assembly register, most significant bit first. The strobe must then go high. When a latch pulse completes (low, then back high) with the strobe high, the assembled word moves into a holding register. The holding register drives a downstream converter in straight binary. A one-cycle valid pulse marks each new value.

A latch pulse that follows any count of shifted bits other than twelve leaves the held value alone. It produces a one-cycle framing-error pulse instead.

Top module: `setpoint_rx`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `code_o` is 0 (zero current), and `code_valid_o` and `frame_err_o` are 0.
- R2: With the strobe low, each rising edge of `sclk_i` captures `sdata_i`. The first captured bit lands in `code_o[11]` and the twelfth in `code_o[0]`. `code_o` is straight binary: 12'h000 is zero current and 12'hFFF is full scale minus one step.
- R3: Rising edges of `sclk_i` seen while `strobe_i` is high do not shift and do not count as bits.
- R4: A latch pulse (a rising edge of `latch_i` after a low period) taken while `strobe_i` is low has no effect: `code_o` does not change, and no valid or error pulse occurs.
- R5: A latch pulse taken with `strobe_i` high, after other than exactly 12 bits since the last falling edge of the strobe, leaves `code_o` unchanged. It raises `frame_err_o` for one cycle. Valid and error pulses never occur together.
- R6: Each accepted latch updates `code_o` and raises `code_valid_o` for exactly one cycle.
- R7: `code_o` changes only in a cycle where `code_valid_o` is high. Shifting alone never changes it.
- R8: `ready_o` is 1 when the synchronized strobe, latch and serial clock are all high. It is 0 while the strobe is low.
- R9: A falling edge of the strobe restarts the bit count. An aborted partial word followed by a fresh 12-bit word is accepted normally.
- R10: The extreme codes 12'h000, 12'h001 and 12'hFFF are transferred unaltered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Active-low shift enable, asynchronous |
| latch_i | input | 1 | Commit line; a low-then-high pulse commits, asynchronous |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first, asynchronous |
| code_o | output | 12 | Held setpoint, straight binary |
| code_valid_o | output | 1 | One-cycle pulse on each update of `code_o` |
| frame_err_o | output | 1 | One-cycle pulse on a latch with a wrong bit count |
| ready_o | output | 1 | Idle indication (strobe, latch and serial clock all high) |

## Verification
A change on any input reaches the synchronizer output after two system clock edges. The edge detector sees it one cycle later, in combinational logic. The shift register, `code_o`, `code_valid_o` and `frame_err_o` update on the third edge after the input change. `ready_o` follows on the second. The bench changes inputs only on falling clock edges and holds each line level for three cycles. It samples four cycles after the latch line returns high, so every result has settled. Valid and error pulses are counted on every rising edge and compared against the totals the bench expects, which proves that each pulse lasts exactly one cycle and that no extra pulse occurs.

// File: rtl/setpoint_rx_pkg.sv
package setpoint_rx_pkg;
  localparam int unsigned N_LINES = 4;

  typedef enum int unsigned {
    LN_STRB = 0,
    LN_LTCH = 1,
    LN_SCLK = 2,
    LN_SDAT = 3
  } line_e;

  // idle: strobe, latch, serial clock high; data low
  localparam logic [N_LINES-1:0] LINE_IDLE = 4'b0111;
endpackage

// File: rtl/setpoint_rx_sync.sv
module setpoint_rx_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/setpoint_rx_edge.sv
module setpoint_rx_edge #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/setpoint_rx_shifter.sv
module setpoint_rx_shifter #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned CNT_W  = $clog2(CODE_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              full_o
);
  // saturate one above a full word so overruns stay visible
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CODE_W + 1);

  logic [CODE_W-1:0] word_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_inc;

  assign cnt_inc = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= shift_i ? CNT_W'(1) : '0;
    end else if (shift_i) begin
      cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {word_q[CODE_W-2:0], din_i};
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CNT_FULL);
endmodule

// File: rtl/setpoint_rx_hold.sv
module setpoint_rx_hold #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              reject_i,
  input  logic [CODE_W-1:0] word_i,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= load_i;
      err_o   <= reject_i & ~load_i;
      if (load_i) code_o <= word_i;
    end
  end
endmodule

// File: rtl/setpoint_rx.sv
module setpoint_rx
  import setpoint_rx_pkg::*;
#(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              latch_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [CODE_W-1:0] code_o,
  output logic              code_valid_o,
  output logic              frame_err_o,
  output logic              ready_o
);
  localparam int unsigned CNT_W = $clog2(CODE_W + 2);

  logic [N_LINES-1:0] lines_raw, lines_s, lines_rise, lines_fall;
  logic strb_s, ltch_s, sclk_s, sdat_s;
  logic shift_en, strobe_drop, latch_done, accept, reject;
  logic [CODE_W-1:0] asm_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              word_full;

  always_comb begin
    lines_raw          = '0;
    lines_raw[LN_STRB] = strobe_i;
    lines_raw[LN_LTCH] = latch_i;
    lines_raw[LN_SCLK] = sclk_i;
    lines_raw[LN_SDAT] = sdata_i;
  end

  setpoint_rx_sync #(
    .W      (N_LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LINE_IDLE)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lines_raw),
    .q_o   (lines_s)
  );

  setpoint_rx_edge #(
    .W      (N_LINES),
    .RST_VAL(LINE_IDLE)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lines_s),
    .rise_o(lines_rise),
    .fall_o(lines_fall)
  );

  assign strb_s = lines_s[LN_STRB];
  assign ltch_s = lines_s[LN_LTCH];
  assign sclk_s = lines_s[LN_SCLK];
  assign sdat_s = lines_s[LN_SDAT];

  assign shift_en    = lines_rise[LN_SCLK] & ~strb_s;
  assign strobe_drop = lines_fall[LN_STRB];
  // rising latch implies a prior low phase: the pulse is complete
  assign latch_done  = lines_rise[LN_LTCH] & strb_s;
  assign accept      = latch_done & word_full;
  assign reject      = latch_done & ~word_full;

  setpoint_rx_shifter #(
    .CODE_W(CODE_W),
    .CNT_W (CNT_W)
  ) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (strobe_drop),
    .shift_i(shift_en),
    .din_i  (sdat_s),
    .word_o (asm_word),
    .cnt_o  (bit_cnt),
    .full_o (word_full)
  );

  setpoint_rx_hold #(
    .CODE_W(CODE_W)
  ) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .reject_i(reject),
    .word_i  (asm_word),
    .code_o  (code_o),
    .valid_o (code_valid_o),
    .err_o   (frame_err_o)
  );

  assign ready_o = strb_s & ltch_s & sclk_s;
endmodule

// File: rtl/setpoint_rx_chk.sv
module setpoint_rx_chk #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strb_s_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CODE_W-1:0] code_i,
  input logic              valid_i,
  input logic              err_i
);
  p_valid_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_err_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);

  p_no_clash_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && err_i));

  p_exact_count_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> ($past(cnt_i) == CNT_W'(CODE_W)));

  p_strobe_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i || err_i) |-> $past(strb_s_i));

  p_code_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> $stable(code_i));
endmodule

bind setpoint_rx setpoint_rx_chk #(
  .CODE_W(CODE_W),
  .CNT_W (CNT_W)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strb_s_i(strb_s),
  .cnt_i   (bit_cnt),
  .code_i  (code_o),
  .valid_i (code_valid_o),
  .err_i   (frame_err_o)
);

// File: tb/setpoint_rx_tb_top.sv
`timescale 1ns/1ps
module setpoint_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic strb = 1'b1, ltch = 1'b1, sclk = 1'b1, sdat = 1'b0;
  logic [11:0] code;
  logic valid, err, ready;

  int n_chk = 0, n_bad = 0;
  int n_valid = 0, n_err = 0, e_valid = 0, e_err = 0;
  logic [11:0] e_code = '0, sh = '0;
  int nb = 0;

  setpoint_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .strobe_i(strb), .latch_i(ltch), .sclk_i(sclk), .sdata_i(sdat),
    .code_o(code), .code_valid_o(valid), .frame_err_o(err), .ready_o(ready)
  );

  always @(posedge clk) begin
    if (valid) n_valid++;
    if (err)   n_err++;
  end

  task automatic hold_c(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] shift_in(input logic [11:0] s, input bit b);
    return {s[10:0], b};
  endfunction

  task automatic strobe_low();
    if (strb) nb = 0;
    strb = 1'b0;
    hold_c(3);
  endtask

  task automatic strobe_high();
    strb = 1'b1;
    hold_c(3);
  endtask

  task automatic clk_bit(input bit b);
    sdat = b;
    sclk = 1'b0; hold_c(3);
    sclk = 1'b1; hold_c(3);
    if (!strb) begin
      sh = shift_in(sh, b);
      if (nb < 13) nb++;
    end
  endtask

  task automatic latch_pulse();
    ltch = 1'b0; hold_c(3);
    ltch = 1'b1; hold_c(4);
    if (strb) begin
      if (nb == 12) begin e_code = sh; e_valid++; end
      else e_err++;
    end
  endtask

  task automatic send_word(input logic [11:0] w, input int n);
    strobe_low();
    for (int i = 0; i < n; i++) clk_bit(i < 12 ? w[11-i] : bit'($urandom % 2));
    strobe_high();
  endtask

  task automatic verify(input string tag);
    check(code == e_code, {tag, " code"}, code, e_code);
    check(n_valid == e_valid, {tag, " valid count"}, n_valid, e_valid);
    check(n_err == e_err, {tag, " error count"}, n_err, e_err);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5e7_0a11));
    hold_c(3);
    // R1 reset state
    check(code == 12'h000, "R1 code in reset", code, 0);
    check(!valid && !err, "R1 pulses in reset", {valid, err}, 0);
    rst_n = 1'b1;
    hold_c(4);
    check(code == 12'h000, "R1 code after reset", code, 0);
    // R8 idle ready
    check(ready == 1'b1, "R8 ready idle", ready, 1);

    // R2 basic MSB-first transfer
    strobe_low();
    check(ready == 1'b0, "R8 ready strobe low", ready, 0);
    for (int i = 11; i >= 0; i--) clk_bit(bit'((12'hA5C >> i) & 1));
    // R7 shifting leaves the held value alone
    check(code == 12'h000, "R7 code during shift", code, 0);
    strobe_high();
    latch_pulse();
    verify("R2 word A5C");
    check(code == 12'hA5C, "R2 bit order", code, 12'hA5C);

    // R10 extremes
    send_word(12'hFFF, 12); latch_pulse(); verify("R10 FFF");
    send_word(12'h000, 12); latch_pulse(); verify("R10 000");
    send_word(12'h001, 12); latch_pulse(); verify("R10 001");

    // R5 short and long frames
    send_word(12'h3C3, 11); latch_pulse(); verify("R5 short frame");
    send_word(12'h3C3, 13); latch_pulse(); verify("R5 long frame");

    // R3 serial clocks with strobe high are ignored
    send_word(12'h6B1, 12);
    clk_bit(1'b1); clk_bit(1'b0); clk_bit(1'b1);
    latch_pulse(); verify("R3 strobe-high clocks");
    check(code == 12'h6B1, "R3 word intact", code, 12'h6B1);

    // R4 latch while strobe low is ignored
    strobe_low();
    for (int i = 11; i >= 0; i--) clk_bit(bit'((12'h2D4 >> i) & 1));
    latch_pulse();
    verify("R4 latch with strobe low");
    check(code == 12'h6B1, "R4 code kept", code, 12'h6B1);
    strobe_high();
    latch_pulse(); verify("R4 then latch with strobe high");

    // R9 aborted partial word then full word
    send_word(12'hFFF, 5);
    send_word(12'h95A, 12); latch_pulse(); verify("R9 restart");
    check(code == 12'h95A, "R9 word", code, 12'h95A);

    // R6 R2 R5 random traffic
    for (int r = 0; r < 40; r++) begin
      logic [11:0] w;
      int n;
      w = 12'($urandom);
      n = ($urandom % 5 == 0) ? 9 + int'($urandom % 7) : 12;
      send_word(w, n);
      if ($urandom % 4 == 0) begin clk_bit(1'b1); end
      latch_pulse();
      verify("R6 random");
    end

    hold_c(3);
    check(ready == 1'b1, "R8 ready end", ready, 1);
    summary();
    $finish;
  end
endmodule